// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Burst SRAM

This block is a clock-synchronous static memory that takes a read or a write command on every active rising edge. Reads and writes can follow each other back to back with no idle cycle in between, because write data is accepted late. In flow-through mode the data comes one cycle after its command. In pipelined mode it comes two cycles after. A static mode input picks between the two. In flow-through mode, read data is driven straight from the array in the cycle after the command. In pipelined mode it passes through an output register and is driven one cycle later.

A command may start a burst. Later cycles that assert advance step a 2-bit counter over the two low address bits, in either linear or interleaved order. The word is split into 9-bit byte lanes, and each lane has its own write enable. Three chip selects gate new commands. A clock-enable input freezes the whole pipeline. Output enable and sleep act on the output drivers without waiting for a clock. The data bus is modelled as a separate read-data output plus a drive-enable output (`dq_oe_o`).

Top module: `nbt_sram`

## Requirements
- R1: A new command is taken on an active edge (`cke_ni`=0, `sleep_i`=0) with `adv_i`=0. The block is selected only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. When selected, `we_ni`=0 makes a write and `we_ni`=1 makes a read. An unselected command reads and writes nothing.
- R2: In flow-through mode (`pipe_mode_i`=0), a read taken at edge k drives its word between edge k and edge k+1.
- R3: In pipelined mode (`pipe_mode_i`=1), a read taken at edge k drives its word between edge k+1 and edge k+2. Nothing from that read is driven before edge k+1.
- R4: Write data on `wdata_i` is sampled at the first active edge after the write command in flow-through mode, and at the second active edge in pipelined mode.
- R5: Lane i covers bits [9i+8:9i]. It is written only when `be_ni[i]`=0 in the write command's cycle. A write with all of `be_ni` high changes no memory.
- R6: `adv_i`=1 continues the previous command type, and the burst count goes up by 1 modulo 4 on each continue. With `lin_order_i`=1 the two low address bits are the start bits plus the count, modulo 4. With `lin_order_i`=0 they are the start bits XOR the count. The upper address bits stay fixed.
- R7: A continue cycle after a deselected command, or after reset, reads and writes nothing.
- R8: With `cke_ni`=1 the edge is ignored and all state holds. A read being driven keeps driving the same word. Write data is not sampled.
- R9: `dq_oe_o` is 0 whenever `oe_ni`=1, acting without a clock. It is also 0 while a write's data is due. `rdata_o` is zero whenever `dq_oe_o` is 0.
- R10: `sleep_i`=1 forces `dq_oe_o` low at once, and the block ignores every other input on edges while it is high.
- R11: In pipelined mode, a read of an address whose write data arrives at the same edge returns the new data, merged per lane, rather than the old array contents.
- R12: After reset `dq_oe_o` is 0 and no command or write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pipe_mode_i | input | 1 | 1 = pipelined, 0 = flow-through (static) |
| lin_order_i | input | 1 | 1 = linear burst order, 0 = interleaved (static) |
| cke_ni | input | 1 | Active-low clock enable |
| adv_i | input | 1 | 1 = continue burst, 0 = new command |
| we_ni | input | 1 | Active-low write select |
| be_ni | input | NUM_LANES | Active-low lane write enables |
| ce1_ni | input | 1 | Chip select, active low |
| ce2_i | input | 1 | Chip select, active high |
| ce3_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Asynchronous active-low output enable |
| sleep_i | input | 1 | Asynchronous sleep |
| addr_i | input | ADDR_W | Command address |
| wdata_i | input | DATA_W | Late write data |
| rdata_o | output | DATA_W | Read data, zero when not driven |
| dq_oe_o | output | 1 | Data bus drive enable |

## Verification
The bench builds the block with its default parameters: 64 words and four 9-bit lanes, giving a 36-bit word. With only 64 words, burst wrap-around, both burst orders and partial-lane merges can all be reached within a few dozen cycles. The mode and order inputs are changed between resets. This puts flow-through timing, pipelined timing with forwarding of pending write data, and interleaved sequencing all under test in one run.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE, OP_DESEL} op_e;

  function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                           input logic [1:0] cnt,
                                           input logic linear);
    return linear ? (start + cnt) : (start ^ cnt);
  endfunction
endpackage

// File: rtl/nbt_cmd_ctrl.sv
module nbt_cmd_ctrl
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              lin_order_i,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               cur_op_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nxt;
  op_e               op_q, new_op;

  assign cnt_nxt = cnt_q + 2'd1;

  always_comb begin
    if (!sel_i)     new_op = OP_DESEL;
    else if (we_ni) new_op = OP_READ;
    else            new_op = OP_WRITE;
  end

  assign cur_op_o   = adv_i ? op_q : new_op;
  assign cur_addr_o = adv_i ? {base_q[ADDR_W-1:2], burst_lsb(base_q[1:0], cnt_nxt, lin_order_i)}
                            : addr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      op_q   <= OP_IDLE;
    end else if (step_i) begin
      if (!adv_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        op_q   <= new_op;
      end else begin
        cnt_q  <= cnt_nxt;
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(base_q) && $stable(cnt_q) && $stable(op_q)); // R8
  AST_BURST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && adv_i |=> cnt_q == $past(cnt_q) + 2'd1 && $stable(base_q)); // R6
endmodule

// File: rtl/nbt_late_write.sv
module nbt_late_write #(
  parameter int ADDR_W    = 6,
  parameter int NUM_LANES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 step_i,
  input  logic                 pipe_i,
  input  logic                 wr_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [NUM_LANES-1:0] be_i,
  output logic                 wr_en_o,
  output logic [ADDR_W-1:0]    wr_addr_o,
  output logic [NUM_LANES-1:0] wr_be_o
);
  logic                 s1_v, s2_v;
  logic [ADDR_W-1:0]    s1_a, s2_a;
  logic [NUM_LANES-1:0] s1_be, s2_be;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
      s1_a  <= '0;
      s2_a  <= '0;
      s1_be <= '0;
      s2_be <= '0;
    end else if (step_i) begin
      s1_v  <= wr_i && (|be_i); // abort drops here
      s1_a  <= addr_i;
      s1_be <= be_i;
      s2_v  <= s1_v;
      s2_a  <= s1_a;
      s2_be <= s1_be;
    end
  end

  assign wr_en_o   = step_i && (pipe_i ? s2_v : s1_v);
  assign wr_addr_o = pipe_i ? s2_a : s1_a;
  assign wr_be_o   = pipe_i ? s2_be : s1_be;
endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int ADDR_W    = 6,
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 9,
  localparam int DATA_W   = NUM_LANES * LANE_W,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic                 clk_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [NUM_LANES-1:0] wr_be_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] raw;
  logic              hit;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if (wr_be_i[l]) mem[wr_addr_i][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
      end
    end
  end

  assign raw = mem[rd_addr_i];
  assign hit = wr_en_i && (wr_addr_i == rd_addr_i);

  // per-lane bypass of the write landing at this edge
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    assign rd_data_o[g*LANE_W +: LANE_W] = (hit && wr_be_i[g]) ? wr_data_i[g*LANE_W +: LANE_W]
                                                               : raw[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/nbt_read_path.sv
module nbt_read_path #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              pipe_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] arr_data_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              dq_oe_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              r1_v, r2_v, src_v;
  logic [ADDR_W-1:0] r1_a;
  logic [DATA_W-1:0] r2_d, src_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r1_v <= 1'b0;
      r1_a <= '0;
      r2_v <= 1'b0;
      r2_d <= '0;
    end else if (step_i) begin
      r1_v <= rd_i;
      r1_a <= addr_i;
      r2_v <= r1_v;
      r2_d <= arr_data_i;
    end
  end

  assign rd_addr_o = r1_a;
  assign src_v     = pipe_i ? r2_v : r1_v;
  assign src_d     = pipe_i ? r2_d : arr_data_i;
  assign dq_oe_o   = src_v && !oe_ni && !sleep_i;
  assign rdata_o   = dq_oe_o ? src_d : '0;

  AST_SLEEP_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o && rdata_o == '0); // R10
  AST_PIPE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pipe_i && !step_i |=> $stable(r2_v) && $stable(r2_d)); // R8
endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_LANES = 4,
  parameter int LANE_W    = 9,
  localparam int DATA_W   = NUM_LANES * LANE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 pipe_mode_i,
  input  logic                 lin_order_i,
  input  logic                 cke_ni,
  input  logic                 adv_i,
  input  logic                 we_ni,
  input  logic [NUM_LANES-1:0] be_ni,
  input  logic                 ce1_ni,
  input  logic                 ce2_i,
  input  logic                 ce3_ni,
  input  logic                 oe_ni,
  input  logic                 sleep_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 dq_oe_o
);
  logic                 step, sel;
  op_e                  cur_op;
  logic [ADDR_W-1:0]    cur_addr, wr_addr, rd_addr;
  logic                 wr_en;
  logic [NUM_LANES-1:0] wr_be;
  logic [DATA_W-1:0]    arr_data;

  assign step = !cke_ni && !sleep_i;
  assign sel  = !ce1_ni && ce2_i && !ce3_ni;

  nbt_cmd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .step_i(step), .lin_order_i, .adv_i, .we_ni,
    .sel_i(sel), .addr_i, .cur_op_o(cur_op), .cur_addr_o(cur_addr)
  );

  nbt_late_write #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES)) u_wpipe (
    .clk_i, .rst_ni, .step_i(step), .pipe_i(pipe_mode_i),
    .wr_i(cur_op == OP_WRITE), .addr_i(cur_addr), .be_i(~be_ni),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_be_o(wr_be)
  );

  nbt_array #(.ADDR_W(ADDR_W), .NUM_LANES(NUM_LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_be_i(wr_be),
    .wr_data_i(wdata_i), .rd_addr_i(rd_addr), .rd_data_o(arr_data)
  );

  nbt_read_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rpath (
    .clk_i, .rst_ni, .step_i(step), .pipe_i(pipe_mode_i),
    .rd_i(cur_op == OP_READ), .addr_i(cur_addr), .arr_data_i(arr_data),
    .oe_ni, .sleep_i, .rd_addr_o(rd_addr), .dq_oe_o, .rdata_o
  );

  AST_NO_BUS_CLASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !dq_oe_o); // R9
  AST_OE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o); // R9
endmodule

// File: tb/nbt_sram_tb_top.sv
module nbt_sram_tb_top;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int DW = NL * 9;

  typedef struct packed {
    logic          cke_n;
    logic          adv;
    logic          we_n;
    logic [NL-1:0] be_n;
    logic [1:0]    sel;   // 0 selected, 1 ce1 high, 2 ce2 low, 3 ce3 high
    logic          oe_n;
    logic          slp;
    logic [AW-1:0] addr;
    logic [DW-1:0] wd;
    logic          eoe;
    logic [DW-1:0] ed;
    logic [3:0]    req;
  } vec_t;

  // flow-through, linear order; row i expectation sampled after the edge that took row i
  localparam int NV = 27;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,4'h0,2'd0,1'b0,1'b0,6'd8, 36'h0,  1'b0,36'h0,  4'd4},  // R4 write 8
    '{1'b0,1'b0,1'b0,4'h0,2'd0,1'b0,1'b0,6'd10,36'h111,1'b0,36'h0,  4'd4},  // R4 data for 8
    '{1'b0,1'b0,1'b1,4'hF,2'd0,1'b0,1'b0,6'd8, 36'h0,  1'b1,36'h111,4'd2},  // R2 R1
    '{1'b0,1'b0,1'b0,4'hE,2'd0,1'b0,1'b0,6'd10,36'h0,  1'b0,36'h0,  4'd9},  // R9 write cycle
    '{1'b0,1'b0,1'b1,4'hF,2'd0,1'b0,1'b0,6'd10,36'hFFFFFFFFF,1'b1,36'h1FF,4'd5}, // R5 lane 0
    '{1'b0,1'b0,1'b0,4'hF,2'd0,1'b0,1'b0,6'd10,36'h0,  1'b0,36'h0,  4'd5},  // R5 abort
    '{1'b0,1'b0,1'b1,4'hF,2'd0,1'b0,1'b0,6'd10,36'h0,  1'b1,36'h1FF,4'd5},  // R5 unchanged
    '{1'b0,1'b0,1'b1,4'hF,2'd1,1'b0,1'b0,6'd8, 36'h0,  1'b0,36'h0,  4'd1},  // R1 ce1 high
    '{1'b0,1'b1,1'b1,4'hF,2'd0,1'b0,1'b0,6'd8, 36'h0,  1'b0,36'h0,  4'd7},  // R7 deselect continue
    '{1'b0,1'b0,1'b1,4'hF,2'd0,1'b1,1'b0,6'd8, 36'h0,  1'b0,36'h0,  4'd9},  // R9 dummy read
    '{1'b0,1'b0,1'b0,4'h0,2'd0,1'b0,1'b0,6'd9, 36'h0,  1'b0,36'h0,  4'd6},  // R6 burst write 9
    '{1'b0,1'b1,1'b0,4'h0,2'd0,1'b0,1'b0,6'd0, 36'h9,  1'b0,36'h0,  4'd6},  // ->10
    '{1'b0,1'b1,1'b0,4'h0,2'd0,1'b0,1'b0,6'd0, 36'hA,  1'b0,36'h0,  4'd6},  // ->11
    '{1'b0,1'b1,1'b0,4'h0,2'd0,1'b0,1'b0,6'd0, 36'hB,  1'b0,36'h0,  4'd6},  // ->8
    '{1'b0,1'b0,1'b1,4'hF,2'd0,1'b0,1'b0,6'd9, 36'h8,  1'b1,36'h9,  4'd6},  // R6 burst read 9
    '{1'b0,1'b1,1'b1,4'hF,2'd0,1'b0,1'b0,6'd0, 36'h0,  1'b1,36'hA,  4'd6},
    '{1'b0,1'b1,1'b1,4'hF,2'd0,1'b0,1'b0,6'd0, 36'h0,  1'b1,36'hB,  4'd6},
    '{1'b0,1'b1,1'b1,4'hF,2'd0,1'b0,1'b0,6'd0, 36'h0,  1'b1,36'h8,  4'd6},  // R6 wrap
    '{1'b1,1'b1,1'b1,4'hF,2'd0,1'b0,1'b0,6'd0, 36'h0,  1'b1,36'h8,  4'd8},  // R8 stall holds
    '{1'b0,1'b1,1'b1,4'hF,2'd0,1'b0,1'b0,6'd0, 36'h0,  1'b1,36'h9,  4'd6},  // R6 count mod 4
    '{1'b0,1'b0,1'b0,4'h0,2'd0,1'b0,1'b0,6'd11,36'h0,  1'b0,36'h0,  4'd8},
    '{1'b1,1'b0,1'b1,4'hF,2'd0,1'b0,1'b0,6'd0, 36'hFF, 1'b0,36'h0,  4'd8},  // R8 data not taken
    '{1'b0,1'b0,1'b1,4'hF,2'd0,1'b0,1'b0,6'd11,36'h123,1'b1,36'h123,4'd8},  // R8
    '{1'b0,1'b0,1'b1,4'hF,2'd0,1'b0,1'b1,6'd8, 36'h0,  1'b0,36'h0,  4'd10}, // R10 sleep
    '{1'b0,1'b1,1'b1,4'hF,2'd0,1'b0,1'b0,6'd0, 36'h0,  1'b1,36'h8,  4'd10}, // R10 command ignored
    '{1'b0,1'b0,1'b1,4'hF,2'd3,1'b0,1'b0,6'd9, 36'h0,  1'b0,36'h0,  4'd1},  // R1 ce3 high
    '{1'b0,1'b0,1'b1,4'hF,2'd2,1'b0,1'b0,6'd9, 36'h0,  1'b0,36'h0,  4'd1}   // R1 ce2 low
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pipe_mode_i = 1'b0, lin_order_i = 1'b1;
  logic cke_ni = 1'b0, adv_i = 1'b0, we_ni = 1'b1;
  logic [NL-1:0] be_ni = '1;
  logic ce1_ni = 1'b1, ce2_i = 1'b1, ce3_ni = 1'b0;
  logic oe_ni = 1'b0, sleep_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic dq_oe_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  nbt_sram dut_i (
    .clk_i, .rst_ni, .pipe_mode_i, .lin_order_i, .cke_ni, .adv_i, .we_ni, .be_ni,
    .ce1_ni, .ce2_i, .ce3_ni, .oe_ni, .sleep_i, .addr_i, .wdata_i, .rdata_o, .dq_oe_o
  );

  task automatic drv(input logic cke_n, input logic adv, input logic we_n,
                     input logic [NL-1:0] be_n, input logic [1:0] sel, input logic oe_n,
                     input logic slp, input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    cke_ni = cke_n; adv_i = adv; we_ni = we_n; be_ni = be_n;
    ce1_ni = (sel == 2'd1); ce2_i = (sel != 2'd2); ce3_ni = (sel == 2'd3);
    oe_ni = oe_n; sleep_i = slp; addr_i = addr; wdata_i = wd;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input int req, input logic eoe, input logic [DW-1:0] ed);
    logic [DW-1:0] exp_d;
    exp_d = eoe ? ed : '0;
    checks++;
    if (dq_oe_o !== eoe || rdata_o !== exp_d) begin
      fails++;
      $display("FAIL R%0d: oe=%0b data=%h expected oe=%0b data=%h", req, dq_oe_o, rdata_o, eoe, exp_d);
    end
  endtask

  task automatic do_reset(input logic pipe, input logic lin);
    @(negedge clk_i);
    rst_ni = 1'b0;
    pipe_mode_i = pipe; lin_order_i = lin;
    drv(1'b0, 1'b0, 1'b1, '1, 2'd1, 1'b0, 1'b0, '0, '0);
    tick();
    rst_ni = 1'b1;
  endtask

  initial begin
    // R12 reset state
    do_reset(1'b0, 1'b1);
    chk(12, 1'b0, '0);
    // R7 continue straight after reset
    drv(1'b0, 1'b1, 1'b1, '1, 2'd0, 1'b0, 1'b0, 6'd3, '0);
    tick();
    chk(7, 1'b0, '0);

    // vector table, flow-through linear
    do_reset(1'b0, 1'b1);
    drv(TBL[0].cke_n, TBL[0].adv, TBL[0].we_n, TBL[0].be_n, TBL[0].sel,
        TBL[0].oe_n, TBL[0].slp, TBL[0].addr, TBL[0].wd);
    for (int i = 0; i < NV; i++) begin
      tick();
      chk(int'(TBL[i].req), TBL[i].eoe, TBL[i].ed);
      if (i + 1 < NV)
        drv(TBL[i+1].cke_n, TBL[i+1].adv, TBL[i+1].we_n, TBL[i+1].be_n, TBL[i+1].sel,
            TBL[i+1].oe_n, TBL[i+1].slp, TBL[i+1].addr, TBL[i+1].wd);
    end

    // pipelined: double-late write, output register, forwarding
    do_reset(1'b1, 1'b1);
    drv(1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0, 6'd4, '0);      // write 4
    tick();
    drv(1'b0, 1'b0, 1'b1, 4'hF, 2'd0, 1'b0, 1'b0, 6'd4, '0);      // read 4
    tick();
    chk(3, 1'b0, '0);                                             // R3 not yet driven
    drv(1'b0, 1'b0, 1'b1, 4'hF, 2'd1, 1'b0, 1'b0, 6'd0, 36'hABC); // R4 data two edges late
    tick();
    chk(11, 1'b1, 36'hABC);                                       // R11 forwarded
    drv(1'b0, 1'b0, 1'b1, 4'hF, 2'd0, 1'b0, 1'b0, 6'd4, '0);      // read 4
    tick();
    chk(3, 1'b0, '0);
    drv(1'b0, 1'b0, 1'b1, 4'hF, 2'd1, 1'b0, 1'b0, 6'd0, '0);
    tick();
    chk(3, 1'b1, 36'hABC);                                        // R3 k+1
    drv(1'b1, 1'b0, 1'b1, 4'hF, 2'd0, 1'b0, 1'b0, 6'd7, '0);      // stall
    tick();
    chk(8, 1'b1, 36'hABC);                                        // R8 keeps driving
    drv(1'b0, 1'b0, 1'b1, 4'hF, 2'd1, 1'b0, 1'b0, 6'd0, '0);
    tick();
    chk(3, 1'b0, '0);
    drv(1'b0, 1'b0, 1'b0, 4'hD, 2'd0, 1'b0, 1'b0, 6'd4, '0);      // lane 1 only
    tick();
    drv(1'b0, 1'b0, 1'b1, 4'hF, 2'd0, 1'b0, 1'b0, 6'd4, '0);
    tick();
    drv(1'b0, 1'b0, 1'b1, 4'hF, 2'd1, 1'b0, 1'b0, 6'd0, 36'h3FE00);
    tick();
    chk(11, 1'b1, 36'h3FEBC);                                     // R11 R5 lane merge
    oe_ni = 1'b1; #1;
    chk(9, 1'b0, '0);                                             // R9 async
    oe_ni = 1'b0; #1;
    chk(9, 1'b1, 36'h3FEBC);
    sleep_i = 1'b1; #1;
    chk(10, 1'b0, '0);                                            // R10 async
    sleep_i = 1'b0;

    // interleaved order, flow-through
    do_reset(1'b0, 1'b0);
    drv(1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0, 6'd12, '0);
    tick();
    for (int a = 13; a <= 15; a++) begin
      drv(1'b0, 1'b0, 1'b0, 4'h0, 2'd0, 1'b0, 1'b0, AW'(a), DW'(a - 1));
      tick();
    end
    drv(1'b0, 1'b0, 1'b1, 4'hF, 2'd0, 1'b0, 1'b0, 6'd13, 36'd15);
    tick();
    chk(6, 1'b1, 36'd13);
    drv(1'b0, 1'b1, 1'b1, 4'hF, 2'd0, 1'b0, 1'b0, 6'd0, '0);
    tick();
    chk(6, 1'b1, 36'd12);                                         // R6 01^01
    tick();
    chk(6, 1'b1, 36'd15);                                         // R6 01^10
    tick();
    chk(6, 1'b1, 36'd14);                                         // R6 01^11

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R12: watchdog expired, actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule